// File: doc/BRIEF.md
# Program Counter and Exception Register Unit

This unit keeps the program counter of a multicycle processor, along with the saved-return address register and the exception cause register. Every cycle it picks a candidate next PC from five sources: the combinational ALU result, the registered ALU output, a jump target built from the instruction word, a fixed exception-handler entry address, or the saved return address. It then decides whether the PC register actually loads that candidate.

The PC loads when the unconditional-write control is high. It also loads when the conditional-write control is high and the branch test passes. The branch test is the ALU zero flag, and it is inverted when the branch-on-not-equal control is set. A return-from-exception strobe copies the saved return address back into the PC. The strobe overrides whatever the source select asks for.

When an exception is taken, the control sequencer raises the save-address write, which captures the current ALU result (the address of the faulting instruction). It also raises the cause write, which records a one-bit reason code. The ALU and the control sequencer sit outside this unit.

Top module: `pc_exc_unit`

## Requirements
- R1: While `rst_n` is low, `pc`, `epc` and `cause` are all 0 after the next rising clock edge.
- R2: With `pc_src`=2'b00 and a PC write, `pc` takes `alu_res` at the next edge.
- R3: With `pc_src`=2'b01 and a PC write, `pc` takes `alu_out` at the next edge.
- R4: With `pc_src`=2'b10 and a PC write, `pc` takes {current `pc`[31:28], `instr`[25:0], 2'b00}. The instruction bits [31:26] have no effect.
- R5: With `pc_src`=2'b11 and a PC write, `pc` becomes 32'hC000_0000.
- R6: With `pc_wr_cond` high and `pc_wr` low, the PC loads only when (`zero` XOR `br_ne`) is 1. So `br_ne`=0 branches when zero=1, and `br_ne`=1 branches when zero=0. With `pc_wr` high the PC loads whatever the branch test gives.
- R7: When `pc_wr`, `pc_wr_cond` and `rfe` are all low, `pc` keeps its value whatever `pc_src`, `zero` and the data inputs are.
- R8: `epc_wr` loads `alu_res` into `epc` at the next edge. Without it, `epc` holds.
- R9: `cause_wr` loads `cause` with 31 zero bits above `int_cause` in bit 0, where 1 means arithmetic overflow and 0 means undefined opcode. Without it, `cause` holds.
- R10: `rfe` loads `pc` from `epc` and takes priority over `pc_src`, `pc_wr` and the branch test. If `epc_wr` is high in the same cycle, `pc` gets the value `epc` held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_src | input | 2 | Next-PC source select |
| pc_wr | input | 1 | Unconditional PC write |
| pc_wr_cond | input | 1 | Conditional PC write (branch) |
| br_ne | input | 1 | Invert branch test (not-equal branch) |
| zero | input | 1 | ALU zero flag |
| rfe | input | 1 | Return-from-exception strobe |
| epc_wr | input | 1 | Save-address register write |
| cause_wr | input | 1 | Cause register write |
| int_cause | input | 1 | Cause code: 1 overflow, 0 undefined opcode |
| alu_res | input | 32 | Combinational ALU result |
| alu_out | input | 32 | Registered ALU output |
| instr | input | 32 | Current instruction word |
| pc | output | 32 | Program counter |
| epc | output | 32 | Saved return address |
| cause | output | 32 | Exception cause |

## Verification
The properties assume the control inputs are already settled at each rising edge and are never unknown after reset. They also assume `pc_src` is treated as meaningful only in a cycle with a PC write. The checks that compare against the exception vector or `alu_res` therefore fire only when a write is actually requested. The stimulus changes every input on the falling edge and holds it through the following rising edge. It drives `pc_src`, `zero` and the data buses with deliberately misleading values in no-write cycles, so that the hold properties are exercised against real noise.

// File: rtl/pc_exc_pkg.sv
package pc_exc_pkg;
    typedef enum logic [1:0] {
        SEL_ALU_RES = 2'b00,
        SEL_ALU_OUT = 2'b01,
        SEL_JUMP    = 2'b10,
        SEL_VECTOR  = 2'b11
    } pc_sel_e;
endpackage

// File: rtl/pc_write_gate.sv
module pc_write_gate (
    input  logic pc_wr,
    input  logic pc_wr_cond,
    input  logic br_ne,
    input  logic zero,
    input  logic rfe,
    output logic load
);
    logic branch_ok;

    always_comb begin
        branch_ok = br_ne ? ~zero : zero;
        load      = rfe | pc_wr | (pc_wr_cond & branch_ok);
    end
endmodule

// File: rtl/pc_next_mux.sv
module pc_next_mux
    import pc_exc_pkg::*;
#(
    parameter int          XLEN   = 32,
    parameter logic [31:0] VECTOR = 32'hC000_0000
) (
    input  logic [1:0]      pc_src,
    input  logic            rfe,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] epc,
    input  logic [XLEN-1:0] alu_res,
    input  logic [XLEN-1:0] alu_out,
    input  logic [XLEN-1:0] instr,
    output logic [XLEN-1:0] pc_next
);
    localparam int JIDX_W = XLEN - 6;

    logic [XLEN-1:0] jump_tgt;
    logic [XLEN-1:0] sel_val;

    always_comb begin
        jump_tgt = {pc[XLEN-1 -: 4], instr[JIDX_W-1:0], 2'b00};
        unique case (pc_sel_e'(pc_src))
            SEL_ALU_RES: sel_val = alu_res;
            SEL_ALU_OUT: sel_val = alu_out;
            SEL_JUMP:    sel_val = jump_tgt;
            SEL_VECTOR:  sel_val = VECTOR[XLEN-1:0];
            default:     sel_val = alu_res;
        endcase
        pc_next = rfe ? epc : sel_val;
    end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               epc_wr,
    input  logic               cause_wr,
    input  logic               int_cause,
    input  logic [XLEN-1:0]    alu_res,
    output logic [XLEN-1:0]    epc,
    output logic [CAUSE_W-1:0] cause
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc   <= '0;
            cause <= '0;
        end else begin
            if (epc_wr)
                epc <= alu_res;
            if (cause_wr)
                cause <= {{(CAUSE_W-1){1'b0}}, int_cause};
        end
    end
endmodule

// File: rtl/pc_exc_unit.sv
module pc_exc_unit #(
    parameter int          XLEN    = 32,
    parameter int          CAUSE_W = 32,
    parameter logic [31:0] VECTOR  = 32'hC000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         pc_src,
    input  logic               pc_wr,
    input  logic               pc_wr_cond,
    input  logic               br_ne,
    input  logic               zero,
    input  logic               rfe,
    input  logic               epc_wr,
    input  logic               cause_wr,
    input  logic               int_cause,
    input  logic [XLEN-1:0]    alu_res,
    input  logic [XLEN-1:0]    alu_out,
    input  logic [XLEN-1:0]    instr,
    output logic [XLEN-1:0]    pc,
    output logic [XLEN-1:0]    epc,
    output logic [CAUSE_W-1:0] cause
);
    logic            pc_load;
    logic [XLEN-1:0] pc_next;

    pc_write_gate u_gate (
        .pc_wr      (pc_wr),
        .pc_wr_cond (pc_wr_cond),
        .br_ne      (br_ne),
        .zero       (zero),
        .rfe        (rfe),
        .load       (pc_load)
    );

    pc_next_mux #(.XLEN(XLEN), .VECTOR(VECTOR)) u_mux (
        .pc_src  (pc_src),
        .rfe     (rfe),
        .pc      (pc),
        .epc     (epc),
        .alu_res (alu_res),
        .alu_out (alu_out),
        .instr   (instr),
        .pc_next (pc_next)
    );

    exc_state_regs #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_exc (
        .clk       (clk),
        .rst_n     (rst_n),
        .epc_wr    (epc_wr),
        .cause_wr  (cause_wr),
        .int_cause (int_cause),
        .alu_res   (alu_res),
        .epc       (epc),
        .cause     (cause)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else if (pc_load)
            pc <= pc_next;
    end
endmodule

// File: rtl/pc_exc_unit_chk.sv
module pc_exc_unit_chk #(
    parameter int          XLEN    = 32,
    parameter int          CAUSE_W = 32,
    parameter logic [31:0] VECTOR  = 32'hC000_0000
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         pc_src,
    input logic               pc_wr,
    input logic               pc_wr_cond,
    input logic               rfe,
    input logic               epc_wr,
    input logic               cause_wr,
    input logic               int_cause,
    input logic [XLEN-1:0]    alu_res,
    input logic [XLEN-1:0]    pc,
    input logic [XLEN-1:0]    epc,
    input logic [CAUSE_W-1:0] cause
);
    // R5
    vector_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr && !rfe && pc_src == 2'b11) |=> pc == VECTOR[XLEN-1:0]);

    // R2
    alu_res_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr && !rfe && pc_src == 2'b00) |=> pc == $past(alu_res));

    // R10
    rfe_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfe |=> pc == $past(epc));

    // R7
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rfe && !pc_wr && !pc_wr_cond) |=> $stable(pc));

    // R8
    epc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        epc_wr |=> epc == $past(alu_res));

    // R8
    epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !epc_wr |=> $stable(epc));

    // R9
    cause_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cause_wr |=> cause == {{(CAUSE_W-1){1'b0}}, $past(int_cause)});

    // R9
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_wr |=> $stable(cause));
endmodule

bind pc_exc_unit pc_exc_unit_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .VECTOR(VECTOR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_src     (pc_src),
    .pc_wr      (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .rfe        (rfe),
    .epc_wr     (epc_wr),
    .cause_wr   (cause_wr),
    .int_cause  (int_cause),
    .alu_res    (alu_res),
    .pc         (pc),
    .epc        (epc),
    .cause      (cause)
);

// File: tb/pc_exc_unit_bench.sv
`timescale 1ns/1ps
module pc_exc_unit_bench;
    typedef struct packed {
        logic [1:0]  src;
        logic        wr;
        logic        wrc;
        logic        ne;
        logic        z;
        logic        rfe;
        logic        ew;
        logic        cw;
        logic        ic;
        logic [31:0] ar;
        logic [31:0] ao;
        logic [31:0] ins;
        logic [31:0] e_pc;
        logic [31:0] e_epc;
        logic [31:0] e_cause;
    } vec_t;

    localparam int NV = 14;
    // src wr wrc ne z rfe ew cw ic alu_res alu_out instr | exp pc, epc, cause
    localparam vec_t VECS [NV] = '{
        '{2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'hA000_0000, 32'h0, 32'h0,           32'hA000_0000, 32'h0, 32'h0},
        '{2'd1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h5, 32'h0000_0100, 32'h0,           32'h0000_0100, 32'h0, 32'h0},
        '{2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h5, 32'h0000_0200, 32'h0,           32'h0000_0100, 32'h0, 32'h0},
        '{2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h5, 32'h0000_0300, 32'h0,           32'h0000_0300, 32'h0, 32'h0},
        '{2'd1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h5, 32'h0000_0400, 32'h0,           32'h0000_0300, 32'h0, 32'h0},
        '{2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'hA000_0000, 32'h7, 32'h0,           32'hA000_0000, 32'h0, 32'h0},
        '{2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h5, 32'h7, 32'hFC00_0010,           32'hA000_0040, 32'h0, 32'h0},
        '{2'd3,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 32'hA000_003C, 32'h7, 32'h0,           32'hC000_0000, 32'hA000_003C, 32'h1},
        '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 32'h5, 32'h7, 32'h0,                   32'hC000_0000, 32'hA000_003C, 32'h0},
        '{2'd0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 32'h1234, 32'h7, 32'h0,                32'hA000_003C, 32'hA000_003C, 32'h0},
        '{2'd3,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hA000_003C, 32'hA000_003C, 32'h0},
        '{2'd1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h5, 32'h0000_0500, 32'h0,           32'h0000_0500, 32'hA000_003C, 32'h0},
        '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 32'h0000_0777, 32'h7, 32'h0,           32'hA000_003C, 32'h0000_0777, 32'h0},
        '{2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 32'h5, 32'h0000_0900, 32'h0,           32'hA000_003C, 32'h0000_0777, 32'h1}
    };
    // requirement each row targets, for messages
    localparam string TAGS [NV] = '{"R2", "R6", "R6", "R6", "R6", "R2", "R4", "R5/R8/R9",
                                    "R9", "R10", "R7", "R6", "R10", "R6"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pc_src = '0;
    logic        pc_wr = 1'b0, pc_wr_cond = 1'b0, br_ne = 1'b0, zero = 1'b0;
    logic        rfe = 1'b0, epc_wr = 1'b0, cause_wr = 1'b0, int_cause = 1'b0;
    logic [31:0] alu_res = '0, alu_out = '0, instr = '0;
    logic [31:0] pc, epc, cause;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    pc_exc_unit u_pc_exc_unit (
        .clk(clk), .rst_n(rst_n), .pc_src(pc_src), .pc_wr(pc_wr),
        .pc_wr_cond(pc_wr_cond), .br_ne(br_ne), .zero(zero), .rfe(rfe),
        .epc_wr(epc_wr), .cause_wr(cause_wr), .int_cause(int_cause),
        .alu_res(alu_res), .alu_out(alu_out), .instr(instr),
        .pc(pc), .epc(epc), .cause(cause)
    );

    task automatic check3(input string tag, input logic [31:0] xp,
                          input logic [31:0] xe, input logic [31:0] xc);
        checks++;
        if (pc !== xp || epc !== xe || cause !== xc) begin
            failures++;
            $display("FAIL %s: pc=%h epc=%h cause=%h expected pc=%h epc=%h cause=%h",
                     tag, pc, epc, cause, xp, xe, xc);
        end
    endtask

    task automatic idle();
        pc_src = '0; pc_wr = 0; pc_wr_cond = 0; br_ne = 0; zero = 0;
        rfe = 0; epc_wr = 0; cause_wr = 0; int_cause = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset with noisy write requests
        @(negedge clk);
        pc_wr = 1; epc_wr = 1; cause_wr = 1; int_cause = 1; alu_res = 32'hDEAD_BEEF;
        @(posedge clk); @(negedge clk);
        check3("R1", 32'h0, 32'h0, 32'h0);
        idle();
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            pc_src = VECS[i].src; pc_wr = VECS[i].wr; pc_wr_cond = VECS[i].wrc;
            br_ne = VECS[i].ne; zero = VECS[i].z; rfe = VECS[i].rfe;
            epc_wr = VECS[i].ew; cause_wr = VECS[i].cw; int_cause = VECS[i].ic;
            alu_res = VECS[i].ar; alu_out = VECS[i].ao; instr = VECS[i].ins;
            @(posedge clk); @(negedge clk);
            check3(TAGS[i], VECS[i].e_pc, VECS[i].e_epc, VECS[i].e_cause);
        end

        // R3: registered ALU output selected directly
        idle();
        pc_wr = 1; pc_src = 2'b01; alu_out = 32'h0000_0ABC; alu_res = 32'h1;
        @(posedge clk); @(negedge clk);
        check3("R3", 32'h0000_0ABC, 32'h0000_0777, 32'h1);

        // R7: several idle cycles with noise on data and select
        idle();
        pc_src = 2'b11; zero = 1; alu_res = '1; alu_out = '1; instr = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check3("R7", 32'h0000_0ABC, 32'h0000_0777, 32'h1);

        // R1: reset in mid-run clears everything
        idle();
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check3("R1", 32'h0, 32'h0, 32'h0);
        rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule